// File: doc/BRIEF.md
# Multi-Lane ADC Frame Serializer

This block takes a set of eight 18-bit conversion results and sends them as one frame over up to four serial lanes, together with a bit clock and a frame marker. Each result is placed in a 24-bit word. The result occupies the upper 18 bits and is shifted out most significant bit first, followed by six zero bits. Two configuration pins select the lane count (four lanes, or two lanes) and the launch rate (one bit per bit-clock edge, or one bit per bit-clock period). The configuration is captured when a frame starts.

Sample sets enter through a valid/ready stream. A transfer happens on a rising `clk` edge where `smp_valid` and `smp_ready` are both high. While valid is high, the source holds `smp_valid` and `smp_data` steady until the transfer. `smp_ready` never depends on `smp_valid`. Ready is high when the block is locked and either idle or in the last clock of the current frame, so frames can follow one another with no gap.

After reset the block stays silent and refuses data until a `sync_pulse` is seen. A sync pulse also cancels any frame in progress, so the next frame starts with its first bit, which is the first bit of channel 0, at the rise of the frame marker.

Top module: `adc_frame_serializer`

## Requirements
- R1: While reset is held and in the first cycle after it, `lane_data`, `bitclk_out`, `frame_mark_out` and `smp_ready` are all 0.
- R2: Until the first `sync_pulse` after reset, `smp_ready` stays 0 and all outputs stay low, even with `smp_valid` high. In the cycle after the pulse, `smp_ready` is 1.
- R3: `smp_ready` is 0 in any cycle where `sync_pulse` is high. A sync pulse during a frame aborts it: in the next cycle `lane_data`, `bitclk_out` and `frame_mark_out` are 0 and `smp_ready` is 1.
- R4: `smp_ready` is 0 inside a frame, except in its last clock, where it is 1. A set accepted in that last clock starts its frame in the very next cycle, with no idle cycle.
- R5: A lane carries each channel as a 24-bit word: sample bit 17 first, down to bit 0, then six 0 bits. Channel c is `smp_data[18*c+17 : 18*c]`.
- R6: With `cfg_dual_lane`=0, lane 3-(c mod 4) carries channel c in word slot c/4. Each lane sends 48 bits per frame.
- R7: With `cfg_dual_lane`=1, lane 3 carries the even channels and lane 1 the odd channels, channel c in word slot c/2. Each lane sends 96 bits. Lanes 2 and 0 stay 0 for the whole frame.
- R8: With `cfg_single_rate`=0, bit slot s is held for exactly one `clk` cycle, and `bitclk_out` is 1 for even s and 0 for odd s. A frame lasts 48 (four lanes) or 96 (two lanes) cycles.
- R9: With `cfg_single_rate`=1, each bit slot is held for two `clk` cycles, and `bitclk_out` is 1 in the first of them and 0 in the second. A frame lasts 96 or 192 cycles.
- R10: `frame_mark_out` is 1 for the first half of a frame's bit slots and 0 for the second half. It rises together with bit slot 0.
- R11: The configuration pins are sampled only at the edge that accepts a set. Changing them during a frame does not alter that frame.
- R12: Whenever no frame is active, `lane_data`, `bitclk_out` and `frame_mark_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-launch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample set offered |
| smp_ready | output | 1 | Sample set can be taken this cycle |
| smp_data | input | 144 | Eight 18-bit samples, channel 0 in the low bits |
| cfg_single_rate | input | 1 | 1: one bit per bit-clock period, 0: one bit per edge |
| cfg_dual_lane | input | 1 | 1: two lanes (3 and 1), 0: four lanes |
| sync_pulse | input | 1 | Locks the frame start and cancels a running frame |
| lane_data | output | 4 | Serial data lanes |
| bitclk_out | output | 1 | Bit clock |
| frame_mark_out | output | 1 | Frame marker |

## Verification
Every output is a decode of registered state. Bit slot 0 of a frame appears in the `clk` cycle right after the accepting edge, and the clean outputs after a sync pulse appear in the cycle after the pulse. `smp_ready` responds within the same cycle only to `sync_pulse`. The bench drives inputs on falling edges and samples one time unit later, or on the next falling edge. It then steps one falling edge per clock through a frame: it derives the slot index as t in double-rate mode and t/2 in single-rate mode, and compares every lane and both clocks on each cycle. It checks the idle state on the falling edge right after the last slot.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int AFS_CHANNELS = 8;
  localparam int AFS_SAMPLE_W = 18;
  localparam int AFS_WORD_W   = 24;
  localparam int AFS_LANES    = 4;

  typedef struct packed {
    logic single_rate;
    logic dual_lane;
  } afs_mode_t;

  // lanes left silent in two-lane mode: those at odd distance from the top lane
  function automatic logic [31:0] idle_lane_mask(input int lanes);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < lanes; i++) begin
      if (((lanes - 1 - i) % 2) != 0) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/afs_lane_mux.sv
module afs_lane_mux #(
  parameter int LANE     = 0,
  parameter int LANES    = 4,
  parameter int CHANNELS = 8,
  parameter int SAMPLE_W = 18,
  parameter int WORD_W   = 24,
  parameter int IDX_W    = 7
) (
  input  logic [CHANNELS*SAMPLE_W-1:0] samples_i,
  input  logic [IDX_W-1:0]             slot_i,
  input  logic                         dual_lane_i,
  input  logic                         busy_i,
  output logic                         bit_o
);
  localparam int FROM_TOP    = LANES - 1 - LANE;
  localparam bit NARROW_USE  = (FROM_TOP % 2) == 0;
  localparam int RANK_WIDE   = FROM_TOP;
  localparam int RANK_NARROW = FROM_TOP / 2;
  localparam int SEL_W       = $clog2(CHANNELS * SAMPLE_W);

  logic [SEL_W-1:0] sel;

  always_comb begin
    int word;
    int pos;
    int ch;
    word = int'(slot_i) / WORD_W;
    pos  = int'(slot_i) % WORD_W;
    ch   = dual_lane_i ? word * (LANES / 2) + RANK_NARROW : word * LANES + RANK_WIDE;
    sel  = SEL_W'(ch * SAMPLE_W + SAMPLE_W - 1 - pos);
    bit_o = 1'b0;
    if (busy_i && (!dual_lane_i || NARROW_USE) && pos < SAMPLE_W && ch < CHANNELS)
      bit_o = samples_i[sel];
  end
endmodule

// File: rtl/afs_frame_ctrl.sv
module afs_frame_ctrl
  import afs_pkg::*;
#(
  parameter int FRAME_BITS = 192,
  parameter int LANES      = 4,
  parameter int IDX_W      = $clog2(FRAME_BITS / (LANES / 2) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             sync_i,
  input  afs_mode_t        mode_i,
  output logic             ready_o,
  output logic             load_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] slot_o,
  output afs_mode_t        mode_o,
  output logic             bitclk_o,
  output logic             frame_o
);
  localparam int SLOTS_WIDE   = FRAME_BITS / LANES;
  localparam int SLOTS_NARROW = FRAME_BITS / (LANES / 2);

  logic             locked_q, busy_q, half_q, last;
  logic [IDX_W-1:0] slot_q, slots;
  afs_mode_t        mode_q;

  assign slots   = mode_q.dual_lane ? IDX_W'(SLOTS_NARROW) : IDX_W'(SLOTS_WIDE);
  assign last    = busy_q && (slot_q == slots - IDX_W'(1)) && (!mode_q.single_rate || half_q);
  assign ready_o = locked_q && !sync_i && (!busy_q || last);
  assign load_o  = valid_i && ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      busy_q   <= 1'b0;
      half_q   <= 1'b0;
      slot_q   <= '0;
      mode_q   <= '0;
    end else if (sync_i) begin
      locked_q <= 1'b1;
      busy_q   <= 1'b0;
      half_q   <= 1'b0;
      slot_q   <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      half_q <= 1'b0;
      slot_q <= '0;
      mode_q <= mode_i;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        half_q <= 1'b0;
        slot_q <= '0;
      end else if (mode_q.single_rate && !half_q) begin
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
        slot_q <= slot_q + IDX_W'(1);
      end
    end
  end

  assign busy_o   = busy_q;
  assign slot_o   = slot_q;
  assign mode_o   = mode_q;
  assign bitclk_o = busy_q && (mode_q.single_rate ? !half_q : !slot_q[0]);
  assign frame_o  = busy_q && (slot_q < (slots >> 1));

  AST_NO_FRAME_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> !busy_q); // R2
  AST_SYNC_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !busy_q && ready_o); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last && !sync_i |=> $stable(mode_q)); // R11
  AST_MARK_ON_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> slot_q == '0 && !half_q); // R10
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> slot_q < slots); // R8
endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer
  import afs_pkg::*;
#(
  parameter int CHANNELS = AFS_CHANNELS,
  parameter int SAMPLE_W = AFS_SAMPLE_W,
  parameter int WORD_W   = AFS_WORD_W,
  parameter int LANES    = AFS_LANES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_valid,
  output logic                         smp_ready,
  input  logic [CHANNELS*SAMPLE_W-1:0] smp_data,
  input  logic                         cfg_single_rate,
  input  logic                         cfg_dual_lane,
  input  logic                         sync_pulse,
  output logic [LANES-1:0]             lane_data,
  output logic                         bitclk_out,
  output logic                         frame_mark_out
);
  localparam int FRAME_BITS = CHANNELS * WORD_W;
  localparam int IDX_W      = $clog2(FRAME_BITS / (LANES / 2) + 1);
  localparam logic [31:0] IDLE_MASK = idle_lane_mask(LANES);

  logic                         load, busy;
  logic [IDX_W-1:0]             slot;
  afs_mode_t                    cfg_in, mode;
  logic [CHANNELS*SAMPLE_W-1:0] samples_q;

  assign cfg_in.single_rate = cfg_single_rate;
  assign cfg_in.dual_lane   = cfg_dual_lane;

  afs_frame_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .LANES      (LANES),
    .IDX_W      (IDX_W)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (smp_valid),
    .sync_i   (sync_pulse),
    .mode_i   (cfg_in),
    .ready_o  (smp_ready),
    .load_o   (load),
    .busy_o   (busy),
    .slot_o   (slot),
    .mode_o   (mode),
    .bitclk_o (bitclk_out),
    .frame_o  (frame_mark_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) samples_q <= '0;
    else if (load) samples_q <= smp_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    afs_lane_mux #(
      .LANE     (g),
      .LANES    (LANES),
      .CHANNELS (CHANNELS),
      .SAMPLE_W (SAMPLE_W),
      .WORD_W   (WORD_W),
      .IDX_W    (IDX_W)
    ) i_mux (
      .samples_i   (samples_q),
      .slot_i      (slot),
      .dual_lane_i (mode.dual_lane),
      .busy_i      (busy),
      .bit_o       (lane_data[g])
    );
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lane_data == '0 && !bitclk_out && !frame_mark_out); // R12
  AST_UNUSED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode.dual_lane |-> (lane_data & IDLE_MASK[LANES-1:0]) == '0); // R7
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (int'(slot) % WORD_W) >= SAMPLE_W |-> lane_data == '0); // R5
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R4
endmodule

// File: tb/test_adc_frame_serializer.sv
module test_adc_frame_serializer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic [143:0] smp_data = '0;
  logic         cfg_single_rate = 1'b0;
  logic         cfg_dual_lane = 1'b0;
  logic         sync_pulse = 1'b0;
  logic [3:0]   lane_data;
  logic         bitclk_out;
  logic         frame_mark_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_frame_serializer i_adc_frame_serializer (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cfg_single_rate(cfg_single_rate), .cfg_dual_lane(cfg_dual_lane),
    .sync_pulse(sync_pulse), .lane_data(lane_data), .bitclk_out(bitclk_out),
    .frame_mark_out(frame_mark_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [143:0] pat(input int seed);
    logic [143:0] v;
    for (int c = 0; c < 8; c++)
      v[18*c +: 18] = 18'((seed + 1) * 30011 + c * 7919 + (c << 13) + seed * (c << 9));
    return v;
  endfunction

  function automatic logic [3:0] exp_lanes(input logic [143:0] d, input bit two, input int slot);
    logic [3:0] r;
    int w, k, ft, ch;
    w = slot / 24;
    k = slot % 24;
    for (int l = 0; l < 4; l++) begin
      ft = 3 - l;
      r[l] = 1'b0;
      if (two && (ft % 2) != 0) continue;
      ch = two ? w * 2 + ft / 2 : w * 4 + ft;
      if (k < 18 && ch < 8) r[l] = d[18 * ch + 17 - k];
    end
    return r;
  endfunction

  task automatic check_idle(input string req);
    chk(lane_data == 4'h0, req, 32'(lane_data), 0);
    chk(bitclk_out == 1'b0, req, 32'(bitclk_out), 0);
    chk(frame_mark_out == 1'b0, req, 32'(frame_mark_out), 0);
  endtask

  task automatic start(input logic [143:0] d, input bit sdr, input bit two);
    smp_valid = 1'b1; smp_data = d; cfg_single_rate = sdr; cfg_dual_lane = two;
    #1;
    chk(smp_ready == 1'b1, "R4", 32'(smp_ready), 1);
    @(negedge clk);
  endtask

  task automatic check_frame(input logic [143:0] d, input bit sdr, input bit two, input bit wiggle,
                             input bit chain, input logic [143:0] nd, input bit nsdr, input bit ntwo,
                             input int stop_at);
    int slots, cyc, slot, half;
    logic [3:0] el;
    string tag;
    slots = two ? 96 : 48;
    cyc = sdr ? 2 * slots : slots;
    for (int t = 0; t < cyc && t < stop_at; t++) begin
      slot = sdr ? t / 2 : t;
      half = sdr ? t % 2 : 0;
      if (t == 0) begin
        smp_valid = 1'b0;
        if (wiggle) begin cfg_single_rate = ~sdr; cfg_dual_lane = ~two; end
      end
      el = exp_lanes(d, two, slot);
      tag = (slot % 24 >= 18) ? "R5" : (wiggle ? "R11" : (two ? "R7" : "R6"));
      chk(lane_data == el, tag, 32'(lane_data), 32'(el));
      chk(bitclk_out == (sdr ? (half == 0) : (slot % 2 == 0)), sdr ? "R9" : "R8",
          32'(bitclk_out), 32'(sdr ? (half == 0) : (slot % 2 == 0)));
      chk(frame_mark_out == (slot < slots / 2), "R10", 32'(frame_mark_out), 32'(slot < slots / 2));
      if (t == 1) chk(smp_ready == 1'b0, "R4", 32'(smp_ready), 0);
      if (t == cyc - 1) begin
        chk(smp_ready == 1'b1, "R4", 32'(smp_ready), 1);
        if (chain) begin
          smp_valid = 1'b1; smp_data = nd; cfg_single_rate = nsdr; cfg_dual_lane = ntwo;
        end
      end
      @(negedge clk);
    end
    if (!chain && stop_at >= cyc) begin
      check_idle("R12");
      chk(smp_ready == 1'b1, "R4", 32'(smp_ready), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check_idle("R1");
    chk(smp_ready == 1'b0, "R1", 32'(smp_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    chk(smp_ready == 1'b0, "R1", 32'(smp_ready), 0);

    // R2: offered data is refused before the first sync
    smp_valid = 1'b1; smp_data = pat(7);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(smp_ready == 1'b0, "R2", 32'(smp_ready), 0);
      chk(lane_data == 4'h0 && !frame_mark_out && !bitclk_out, "R2", 32'(lane_data), 0);
    end
    smp_valid = 1'b0;
    sync_pulse = 1'b1;
    @(negedge clk);
    sync_pulse = 1'b0;
    #1;
    chk(smp_ready == 1'b1, "R2", 32'(smp_ready), 1);
    @(negedge clk);

    // R3: sync while locked and idle masks ready
    sync_pulse = 1'b1;
    #1;
    chk(smp_ready == 1'b0, "R3", 32'(smp_ready), 0);
    @(negedge clk);
    sync_pulse = 1'b0;
    @(negedge clk);

    // sweep all four modes with chained frames
    for (int m = 0; m < 4; m++) begin
      start(pat(m * 3), m[0], m[1]);
      for (int s = 0; s < 3; s++)
        check_frame(pat(m * 3 + s), m[0], m[1], s == 1, s < 2, pat(m * 3 + s + 1), m[0], m[1], 1 << 20);
      @(negedge clk);
    end

    // R11 and R4: mode switch between chained frames, all-ones payload for padding
    start('1, 1'b0, 1'b0);
    check_frame('1, 1'b0, 1'b0, 1'b1, 1'b1, pat(40), 1'b1, 1'b1, 1 << 20);
    check_frame(pat(40), 1'b1, 1'b1, 1'b0, 1'b1, '1, 1'b1, 1'b1, 1 << 20);
    check_frame('1, 1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1 << 20);

    // R3: abort in mid frame
    start(pat(50), 1'b1, 1'b0);
    check_frame(pat(50), 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 10);
    sync_pulse = 1'b1;
    #1;
    chk(smp_ready == 1'b0, "R3", 32'(smp_ready), 0);
    @(negedge clk);
    sync_pulse = 1'b0;
    #1;
    check_idle("R3");
    chk(smp_ready == 1'b1, "R3", 32'(smp_ready), 1);
    @(negedge clk);
    start(pat(51), 1'b0, 1'b1);
    check_frame(pat(51), 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1 << 20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule